// File: doc/BRIEF.md
# Open-Page DRAM Latency Timer

This block models the timing of a single-bank memory that keeps one page open. Word requests arrive strictly in order through a valid/ready handshake, at most one per clock. The block works out the page of each accepted request and holds ready low for as long as the memory is occupied by that request. When the page matches the one left open by the previous request, the short page-hit latency `T_NEXT` applies. Otherwise, or when no page is open, the full random latency `T_RAND` applies.

No data is stored. Reads and writes cost the same. The block keeps three running counters for the surrounding performance model: page conflicts, busy cycles and bytes moved.

The timing is worst-case. A request presented while the memory is busy waits until the whole current latency has elapsed before it is accepted. The usual configurations are 64-word pages with a 3-cycle hit latency and 1024-word pages with a 2-cycle hit latency. Both use an 8-cycle random latency.

Top module: `page_dram_timer`

## Requirements
- R1: After reset, `req_ready` is 1, `acc_done` is 0, all three counters are 0 and no page is open.
- R2: The page of a request is `req_addr >> log2(PAGE_WORDS)`. A request accepted while no page is open, or whose page differs from the open page, holds `req_ready` low for exactly `T_RAND` cycles after the accepting edge.
- R3: A request whose page equals the page of the previously accepted request holds `req_ready` low for exactly `T_NEXT` cycles after the accepting edge.
- R4: `conflict_cnt` increases by 1 for each accepted request whose page differs from the page of the previously accepted request. The first request after reset is never counted.
- R5: A request is accepted only on an edge where `req_valid` and `req_ready` are both 1. A valid request held while `req_ready` is low changes neither the open page nor any counter.
- R6: `busy_cycles` increases by exactly 1 on every edge where `req_ready` was 0.
- R7: `acc_done` is 1 during the last busy cycle of each request, for one cycle per request. On that edge `byte_cnt` increases by 4.
- R8: `req_write` has no effect on latency, counters or the open page.
- R9: Reset closes any open page, so the first request after reset takes `T_RAND` even when its page matches the page open before reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A request is presented |
| req_write | input | 1 | Request direction (timing-neutral) |
| req_addr | input | ADDR_W | Word address of the request |
| req_ready | output | 1 | Memory idle; request accepted when valid |
| acc_done | output | 1 | Last busy cycle of the current request |
| conflict_cnt | output | CNT_W | Page conflicts since reset |
| busy_cycles | output | CNT_W | Cycles with the memory busy |
| byte_cnt | output | CNT_W | Bytes moved by completed requests |

## Verification
The bench builds the block with 4-word pages, a 5-bit address, `T_RAND` = 5 and `T_NEXT` = 2. With these values the address space holds only 32 words in 8 pages, so every ordered pair of addresses can be run from reset. That sweep covers each same-page and cross-page transition, including pages at both ends of the space.

Distinct latencies make a page hit and a page miss tell apart by ready-low duration alone. The write flag alternates across the sweep. Extra sequences hold a request valid through a busy window and reset while a page is open.

// File: rtl/pdt_pkg.sv
// Shared definitions for the open-page DRAM latency timer.
// Assumes word-sized transfers of BYTES_PER_WORD bytes.
package pdt_pkg;
    localparam int unsigned BYTES_PER_WORD = 4;

    // How an accepted request is costed.
    typedef enum logic {
        ACC_RANDOM   = 1'b0,
        ACC_PAGE_HIT = 1'b1
    } acc_kind_e;
endpackage

// File: rtl/pdt_page_tracker.sv
// Holds the currently open page and classifies each accepted request.
// Assumes one accept at most per cycle and PAGE_BITS < ADDR_W.
module pdt_page_tracker
    import pdt_pkg::*;
#(
    parameter int unsigned ADDR_W    = 16,
    parameter int unsigned PAGE_BITS = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [ADDR_W-1:0] addr,
    output acc_kind_e         kind,
    output logic              conflict
);
    localparam int unsigned PNUM_W = ADDR_W - PAGE_BITS;

    logic [PNUM_W-1:0] open_page;
    logic              open_vld;
    logic [PNUM_W-1:0] req_page;
    logic              same_page;

    // Derive the page number and compare it with the open page.
    always_comb begin
        req_page  = addr[ADDR_W-1:PAGE_BITS];
        same_page = open_vld && (req_page == open_page);
        kind      = same_page ? ACC_PAGE_HIT : ACC_RANDOM;
        conflict  = accept && open_vld && !same_page;
    end

    // Record the page of every accepted request; reset closes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_page <= '0;
            open_vld  <= 1'b0;
        end else if (accept) begin
            open_page <= req_page;
            open_vld  <= 1'b1;
        end
    end
endmodule

// File: rtl/pdt_busy_timer.sv
// Down-counter that models the occupied time of the memory.
// Assumes both latencies are at least 1 and T_NEXT <= T_RAND.
module pdt_busy_timer
    import pdt_pkg::*;
#(
    parameter int unsigned T_RAND = 8,
    parameter int unsigned T_NEXT = 3
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      accept,
    input  acc_kind_e kind,
    output logic      idle,
    output logic      last
);
    localparam int unsigned LAT_W = $clog2(T_RAND + 1);

    logic [LAT_W-1:0] remain;
    logic [LAT_W-1:0] load_val;

    // Pick the latency for the request being accepted.
    always_comb begin
        load_val = (kind == ACC_PAGE_HIT) ? LAT_W'(T_NEXT) : LAT_W'(T_RAND);
        idle     = (remain == '0);
        last     = (remain == LAT_W'(1));
    end

    // Load on accept, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (accept) begin
            remain <= load_val;
        end else if (!idle) begin
            remain <= remain - LAT_W'(1);
        end
    end
endmodule

// File: rtl/pdt_stats.sv
// Conflict, busy-cycle and byte counters for the timing model.
// Assumes CNT_W is wide enough that wrap-around is not a concern.
module pdt_stats
    import pdt_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             conflict,
    input  logic             busy,
    input  logic             done,
    output logic [CNT_W-1:0] conflict_cnt,
    output logic [CNT_W-1:0] busy_cycles,
    output logic [CNT_W-1:0] byte_cnt
);
    // Accumulate the three statistics independently.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            conflict_cnt <= '0;
            busy_cycles  <= '0;
            byte_cnt     <= '0;
        end else begin
            if (conflict) conflict_cnt <= conflict_cnt + CNT_W'(1);
            if (busy)     busy_cycles  <= busy_cycles + CNT_W'(1);
            if (done)     byte_cnt     <= byte_cnt + CNT_W'(BYTES_PER_WORD);
        end
    end
endmodule

// File: rtl/page_dram_timer.sv
// Timing model of a single-bank DRAM with one open page.
// Requests are word-sized, in order, one per cycle at most; reads and
// writes cost the same. Assumes PAGE_WORDS is a power of two >= 2.
module page_dram_timer
    import pdt_pkg::*;
#(
    parameter int unsigned ADDR_W     = 16,
    parameter int unsigned PAGE_WORDS = 64,
    parameter int unsigned T_RAND     = 8,
    parameter int unsigned T_NEXT     = 3,
    parameter int unsigned CNT_W      = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    output logic              acc_done,
    output logic [CNT_W-1:0]  conflict_cnt,
    output logic [CNT_W-1:0]  busy_cycles,
    output logic [CNT_W-1:0]  byte_cnt
);
    localparam int unsigned PAGE_BITS = $clog2(PAGE_WORDS);

    acc_kind_e kind;
    logic      accept;
    logic      conflict;
    logic      idle;
    logic      last;
    logic      unused_write;

    // Handshake: accept only when the memory is idle.
    always_comb begin
        accept       = req_valid && idle;
        req_ready    = idle;
        acc_done     = last;
        unused_write = req_write;
    end

    pdt_page_tracker #(
        .ADDR_W   (ADDR_W),
        .PAGE_BITS(PAGE_BITS)
    ) u_page (
        .clk     (clk),
        .rst_n   (rst_n),
        .accept  (accept),
        .addr    (req_addr),
        .kind    (kind),
        .conflict(conflict)
    );

    pdt_busy_timer #(
        .T_RAND(T_RAND),
        .T_NEXT(T_NEXT)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .accept(accept),
        .kind  (kind),
        .idle  (idle),
        .last  (last)
    );

    pdt_stats #(
        .CNT_W(CNT_W)
    ) u_stats (
        .clk         (clk),
        .rst_n       (rst_n),
        .conflict    (conflict),
        .busy        (!idle),
        .done        (last),
        .conflict_cnt(conflict_cnt),
        .busy_cycles (busy_cycles),
        .byte_cnt    (byte_cnt)
    );
endmodule

// File: rtl/pdt_checker.sv
// Port-level checks for page_dram_timer, attached by bind.
// Assumes reset is held for at least one clock at start.
module pdt_checker #(
    parameter int unsigned T_RAND = 8,
    parameter int unsigned T_NEXT = 3,
    parameter int unsigned CNT_W  = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic             acc_done,
    input logic [CNT_W-1:0] conflict_cnt,
    input logic [CNT_W-1:0] busy_cycles,
    input logic [CNT_W-1:0] byte_cnt
);
    logic        started;
    logic [15:0] gap;

    // Marks that at least one cycle out of reset has passed.
    always_ff @(posedge clk) begin
        if (!rst_n) started <= 1'b0;
        else        started <= 1'b1;
    end

    // Length of the current ready-low stretch.
    always_ff @(posedge clk) begin
        if (!rst_n || req_ready) gap <= '0;
        else                     gap <= gap + 16'd1;
    end

    a_r5_accept_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    a_r2_r3_gap_len: assert property (@(posedge clk) disable iff (!rst_n)
        (started && $rose(req_ready)) |->
            (gap == 16'(T_RAND) || gap == 16'(T_NEXT)));

    a_r4_conflict_step: assert property (@(posedge clk) disable iff (!rst_n)
        started |-> (conflict_cnt - $past(conflict_cnt)) <= CNT_W'(1));

    a_r6_busy_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        started |-> (busy_cycles - $past(busy_cycles)) ==
                    ($past(req_ready) ? CNT_W'(0) : CNT_W'(1)));

    a_r7_bytes_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        (started && byte_cnt != $past(byte_cnt)) |-> $past(acc_done));

    a_r7_done_frees: assert property (@(posedge clk) disable iff (!rst_n)
        acc_done |=> req_ready);
endmodule

bind page_dram_timer pdt_checker #(
    .T_RAND(T_RAND),
    .T_NEXT(T_NEXT),
    .CNT_W (CNT_W)
) u_pdt_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .acc_done    (acc_done),
    .conflict_cnt(conflict_cnt),
    .busy_cycles (busy_cycles),
    .byte_cnt    (byte_cnt)
);

// File: tb/tb_page_dram_timer.sv
// Exhaustive address-pair sweep of page_dram_timer in a small configuration.
module tb_page_dram_timer;
    localparam int ADDR_W = 5;
    localparam int PAGE_WORDS = 4;
    localparam int T_RAND = 5;
    localparam int T_NEXT = 2;
    localparam int CNT_W = 16;
    localparam int NADDR = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              req_ready;
    logic              acc_done;
    logic [CNT_W-1:0]  conflict_cnt;
    logic [CNT_W-1:0]  busy_cycles;
    logic [CNT_W-1:0]  byte_cnt;

    int n_tests = 0;
    int n_fail = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    page_dram_timer #(
        .ADDR_W(ADDR_W), .PAGE_WORDS(PAGE_WORDS),
        .T_RAND(T_RAND), .T_NEXT(T_NEXT), .CNT_W(CNT_W)
    ) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_ready(req_ready), .acc_done(acc_done),
        .conflict_cnt(conflict_cnt), .busy_cycles(busy_cycles), .byte_cnt(byte_cnt)
    );

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        req_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // One request; returns ready-low length and acc_done pulse count.
    // hold_lat > 0 keeps another request valid during the busy window.
    task automatic do_access(input int addr, input bit wr, input int hold_lat,
                             input int hold_addr, output int lat, output int dn);
        int guard;
        guard = 0;
        @(negedge clk);
        while (!req_ready && guard < 100) begin
            guard++;
            @(negedge clk);
        end
        req_valid = 1'b1;
        req_addr  = ADDR_W'(addr);
        req_write = wr;
        @(negedge clk);
        req_valid = 1'b0;
        if (hold_lat > 0) begin
            req_addr  = ADDR_W'(hold_addr);
            req_valid = 1'b1;
        end
        lat = 0;
        dn  = 0;
        while (!req_ready && lat < 100) begin
            lat++;
            if (acc_done) dn++;
            if (hold_lat > 0) req_valid = (lat < hold_lat);
            @(negedge clk);
        end
        req_valid = 1'b0;
    endtask

    initial begin
        int lat;
        int dn;
        int exp_lat;
        bit diff;
        do_reset();
        @(negedge clk);
        // R1: reset state
        check("R1 ready", int'(req_ready), 1);
        check("R1 done", int'(acc_done), 0);
        check("R1 conflicts", int'(conflict_cnt), 0);
        check("R1 busy", int'(busy_cycles), 0);
        check("R1 bytes", int'(byte_cnt), 0);

        // R2 R3 R4 R6 R7 R8: every ordered address pair from reset
        for (int a = 0; a < NADDR; a++) begin
            for (int b = 0; b < NADDR; b++) begin
                do_reset();
                diff = ((a / PAGE_WORDS) != (b / PAGE_WORDS));
                exp_lat = diff ? T_RAND : T_NEXT;
                do_access(a, b[0], 0, 0, lat, dn);
                check("R2 first access latency", lat, T_RAND);
                do_access(b, ~b[0], 0, 0, lat, dn);
                check(diff ? "R2 miss latency" : "R3 hit latency", lat, exp_lat);
                check("R7 done pulse", dn, 1);
                check("R4 conflict count", int'(conflict_cnt), diff ? 1 : 0);
                check("R6 busy cycles", int'(busy_cycles), T_RAND + exp_lat);
                check("R7 bytes (R8 write ignored)", int'(byte_cnt), 8);
            end
        end

        // R5: request held valid through busy window is not taken
        do_reset();
        do_access(0, 1'b0, T_RAND, 20, lat, dn);
        check("R5 latency unchanged", lat, T_RAND);
        check("R5 no extra bytes", int'(byte_cnt), 4);
        check("R5 no conflict", int'(conflict_cnt), 0);
        check("R5 ready idle", int'(req_ready), 1);
        do_access(1, 1'b0, 0, 0, lat, dn);
        check("R5 open page unchanged", lat, T_NEXT);

        // R9: reset closes the open page
        do_reset();
        do_access(8, 1'b1, 0, 0, lat, dn);
        do_access(9, 1'b0, 0, 0, lat, dn);
        check("R3 hit before reset", lat, T_NEXT);
        do_reset();
        do_access(10, 1'b0, 0, 0, lat, dn);
        check("R9 random after reset", lat, T_RAND);
        check("R9 no conflict", int'(conflict_cnt), 0);

        // R4: alternating pages count every change
        do_reset();
        for (int k = 0; k < 6; k++) do_access((k % 2) * 4, 1'b0, 0, 0, lat, dn);
        check("R4 alternating conflicts", int'(conflict_cnt), 5);
        check("R6 alternating busy", int'(busy_cycles), 6 * T_RAND);
        check("R7 alternating bytes", int'(byte_cnt), 24);

        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule